// File: doc/BRIEF.md
# Quad-Rate Four-Beat Burst SRAM Model

This block is a cycle-accurate, synthesizable model of a small synchronous static memory. It has a read data path and a write data path that are fully separate, and a single shared address bus. Everything is clocked by one rising-edge clock, `clk`. Double-rate transfer is represented as two beats per clock cycle: a rise-half beat and a fall-half beat, each on its own bus. Every access is a fixed burst of four words. The burst runs through the aligned group of four that contains the start address, wrapping as needed, and it takes two clock cycles.

A read is issued with `rd_n` low. The read data comes back as beat pairs on `q_rise`/`q_fall`, qualified by `q_valid`. A write is issued with `wr_n` low. Its address is taken from the shared bus on the following edge, together with the first two data beats (late write), and the last two beats follow one cycle later. Each beat has its own byte enables. The `echo` output toggles every cycle as a free-running timing marker. The `k_timing` input selects how read beats are timed: either from the input clock directly, or through the output-clock path, which adds one cycle.

The read control state machine has three states. RD_IDLE moves to RD_B01 when a read is accepted. RD_B01 always moves to RD_B23. RD_B23 moves to RD_B01 when a read is accepted and otherwise returns to RD_IDLE. The write control state machine follows the same pattern. WR_IDLE moves to WR_ADDR when a write is accepted. WR_ADDR always moves to WR_B23. WR_B23 moves to WR_ADDR when a write is accepted and otherwise returns to WR_IDLE.

Top module: `qdr_b4_sram`

## Requirements
- R1: While `rst` is high, `q_valid`, `q_start` and `echo` are 0, `q_rise`/`q_fall` are zero, and every storage word is cleared to zero.
- R2: With `k_timing`=1, a read accepted at edge E puts beats 0 and 1 on `q_rise`/`q_fall` after edge E+1, with `q_start`=1. Beats 2 and 3 follow after edge E+2, with `q_start`=0. `q_valid` is 1 in both cycles.
- R3: Beat n of a burst (n = 0..3) addresses `{base[ADDR_W-1:2], (base[1:0]+n) mod 4}`. The upper address bits never change within a burst.
- R4: A read request at the edge right after an accepted read is ignored. A read at the edge after that is accepted, so reads issued every two cycles stream with no empty cycle between bursts.
- R5: If no read is accepted at the edge that loads beats 2 and 3, then after the next edge `q_valid` and `q_start` are 0 and both read buses are zero.
- R6: A write accepted at edge E takes its base address from `addr` at edge E+1. At E+1 it stores `d_rise`/`d_fall` as beats 0 and 1. At E+2 it stores beats 2 and 3 at the same base.
- R7: A write request at the edge right after an accepted write (its address edge) is ignored.
- R8: Bit i of `be_rise`/`be_fall` enables byte i (bits [8i+7:8i]) of that beat. Bytes whose enable is 0 keep their previous contents.
- R9: A read request at an edge where a write address is being taken from the shared bus is ignored.
- R10: A read beat loaded at an edge returns the word as it was before any write committed at that same edge.
- R11: After reset is released, `echo` inverts at every rising edge.
- R12: With `k_timing`=0, every read output (`q_valid`, `q_start`, `q_rise`, `q_fall`) appears exactly one cycle later than in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| k_timing | input | 1 | 1: read beats timed from the input clock; 0: output-clock path, one cycle later |
| rd_n | input | 1 | Read request, active low |
| wr_n | input | 1 | Write request, active low |
| addr | input | ADDR_W | Shared address bus: read address at request edge, write address one edge after write request |
| be_rise | input | BYTES | Byte enables for the rise-half write beat |
| be_fall | input | BYTES | Byte enables for the fall-half write beat |
| d_rise | input | BYTES*BYTE_W | Rise-half write data beat |
| d_fall | input | BYTES*BYTE_W | Fall-half write data beat |
| q_rise | output | BYTES*BYTE_W | Rise-half read data beat |
| q_fall | output | BYTES*BYTE_W | Fall-half read data beat |
| q_valid | output | 1 | Read beats valid; low stands for the released (high-impedance) bus |
| q_start | output | 1 | Marks the cycle that carries beats 0 and 1 of a burst |
| echo | output | 1 | Free-running echo marker, toggles each cycle |

## Verification
Because the read path and the write path are independent, a read's beat fetch and a write's beat commit can fall on the same edge. The bench provokes this by issuing a read and a write in the same cycle and then presenting the same address as the write address on the next edge. That makes both bursts touch the same four words on the same two edges, and the read must return the contents from before the write. The shared address bus gives a second same-cycle conflict: a read request on a write's address edge, which must be dropped. Both cases are judged beat by beat against a behavioural model. That model keeps its own memory array and burst phases, and it orders its reads ahead of its writes. The same comparison then runs over long random request patterns in both timing modes.

// File: rtl/qdr_b4_pkg.sv
package qdr_b4_pkg;
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_B01  = 2'd1,
        RD_B23  = 2'd2
    } rd_state_e;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_ADDR = 2'd1,
        WR_B23  = 2'd2
    } wr_state_e;
endpackage

// File: rtl/qdr_b4_rd_ctl.sv
module qdr_b4_rd_ctl
    import qdr_b4_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic              wr_slot,
    input  logic [ADDR_W-1:0] addr,
    output rd_state_e         state,
    output logic              fetch,
    output logic              fetch_first,
    output logic [ADDR_W-1:0] fa0,
    output logic [ADDR_W-1:0] fa1
);
    localparam int HI_W = ADDR_W - 2;

    rd_state_e         state_n;
    logic [ADDR_W-1:0] base_q;
    logic              accept;
    logic [HI_W-1:0]   hi;
    logic [1:0]        lo;

    assign accept = !rd_n && !wr_slot && (state != RD_B01);
    assign hi     = base_q[ADDR_W-1:2];
    assign lo     = base_q[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RD_IDLE;
            base_q <= '0;
        end else begin
            state <= state_n;
            if (accept) base_q <= addr;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            RD_IDLE: state_n = accept ? RD_B01 : RD_IDLE;
            RD_B01:  state_n = RD_B23;
            RD_B23:  state_n = accept ? RD_B01 : RD_IDLE;
            default: state_n = RD_IDLE;
        endcase
    end

    always_comb begin
        fetch       = 1'b0;
        fetch_first = 1'b0;
        fa0         = base_q;
        fa1         = base_q;
        unique case (state)
            RD_IDLE: ;
            RD_B01: begin
                fetch       = 1'b1;
                fetch_first = 1'b1;
                fa0         = {hi, lo};
                fa1         = {hi, lo + 2'd1};
            end
            RD_B23: begin
                fetch = 1'b1;
                fa0   = {hi, lo + 2'd2};
                fa1   = {hi, lo + 2'd3};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qdr_b4_wr_ctl.sv
module qdr_b4_wr_ctl
    import qdr_b4_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output wr_state_e         state,
    output logic              wr_slot,
    output logic              commit,
    output logic [ADDR_W-1:0] wa0,
    output logic [ADDR_W-1:0] wa1
);
    wr_state_e         state_n;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] src;
    logic              accept;

    assign accept  = !wr_n && (state != WR_ADDR);
    assign wr_slot = (state == WR_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WR_IDLE;
            base_q <= '0;
        end else begin
            state <= state_n;
            if (state == WR_ADDR) base_q <= addr;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            WR_IDLE: state_n = accept ? WR_ADDR : WR_IDLE;
            WR_ADDR: state_n = WR_B23;
            WR_B23:  state_n = accept ? WR_ADDR : WR_IDLE;
            default: state_n = WR_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        src    = base_q;
        wa0    = base_q;
        wa1    = base_q;
        unique case (state)
            WR_IDLE: ;
            WR_ADDR: begin
                commit = 1'b1;
                src    = addr;
                wa0    = {src[ADDR_W-1:2], src[1:0]};
                wa1    = {src[ADDR_W-1:2], src[1:0] + 2'd1};
            end
            WR_B23: begin
                commit = 1'b1;
                wa0    = {src[ADDR_W-1:2], src[1:0] + 2'd2};
                wa1    = {src[ADDR_W-1:2], src[1:0] + 2'd3};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qdr_b4_store.sv
module qdr_b4_store #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        wa0,
    input  logic [ADDR_W-1:0]        wa1,
    input  logic [BYTES-1:0]         be0,
    input  logic [BYTES-1:0]         be1,
    input  logic [BYTES*BYTE_W-1:0]  wd0,
    input  logic [BYTES*BYTE_W-1:0]  wd1,
    input  logic [ADDR_W-1:0]        ra0,
    input  logic [ADDR_W-1:0]        ra1,
    output logic [BYTES*BYTE_W-1:0]  rd0,
    output logic [BYTES*BYTE_W-1:0]  rd1
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            for (int w = 0; w < DEPTH; w++) begin
                if (rst)
                    lane_q[w] <= '0;
                else if (we && be0[b] && (wa0 == ADDR_W'(w)))
                    lane_q[w] <= wd0[b*BYTE_W +: BYTE_W];
                else if (we && be1[b] && (wa1 == ADDR_W'(w)))
                    lane_q[w] <= wd1[b*BYTE_W +: BYTE_W];
            end
        end

        assign rd0[b*BYTE_W +: BYTE_W] = lane_q[ra0];
        assign rd1[b*BYTE_W +: BYTE_W] = lane_q[ra1];
    end
endmodule

// File: rtl/qdr_b4_out.sv
module qdr_b4_out #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              k_timing,
    input  logic              fetch,
    input  logic              fetch_first,
    input  logic [DATA_W-1:0] pr,
    input  logic [DATA_W-1:0] pf,
    output logic [DATA_W-1:0] q_rise,
    output logic [DATA_W-1:0] q_fall,
    output logic              q_valid,
    output logic              q_start,
    output logic              echo
);
    logic              v1, st1, v2, st2;
    logic [DATA_W-1:0] r1, f1, r2, f2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0; st1 <= 1'b0; r1 <= '0; f1 <= '0;
            v2 <= 1'b0; st2 <= 1'b0; r2 <= '0; f2 <= '0;
            echo <= 1'b0;
        end else begin
            v1   <= fetch;
            st1  <= fetch && fetch_first;
            r1   <= fetch ? pr : '0;
            f1   <= fetch ? pf : '0;
            v2   <= v1;
            st2  <= st1;
            r2   <= r1;
            f2   <= f1;
            echo <= ~echo;
        end
    end

    always_comb begin
        if (k_timing) begin
            q_valid = v1; q_start = st1; q_rise = r1; q_fall = f1;
        end else begin
            q_valid = v2; q_start = st2; q_rise = r2; q_fall = f2;
        end
    end
endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram
    import qdr_b4_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    k_timing,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES-1:0]        be_rise,
    input  logic [BYTES-1:0]        be_fall,
    input  logic [BYTES*BYTE_W-1:0] d_rise,
    input  logic [BYTES*BYTE_W-1:0] d_fall,
    output logic [BYTES*BYTE_W-1:0] q_rise,
    output logic [BYTES*BYTE_W-1:0] q_fall,
    output logic                    q_valid,
    output logic                    q_start,
    output logic                    echo
);
    localparam int DATA_W = BYTES * BYTE_W;

    rd_state_e         rd_state;
    wr_state_e         wr_state;
    logic              wr_slot, commit, fetch, fetch_first;
    logic [ADDR_W-1:0] fa0, fa1, wa0, wa1;
    logic [DATA_W-1:0] pr, pf;

    qdr_b4_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst(rst), .wr_n(wr_n), .addr(addr),
        .state(wr_state), .wr_slot(wr_slot), .commit(commit),
        .wa0(wa0), .wa1(wa1)
    );

    qdr_b4_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_slot(wr_slot), .addr(addr),
        .state(rd_state), .fetch(fetch), .fetch_first(fetch_first),
        .fa0(fa0), .fa1(fa1)
    );

    qdr_b4_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_store (
        .clk(clk), .rst(rst), .we(commit),
        .wa0(wa0), .wa1(wa1), .be0(be_rise), .be1(be_fall),
        .wd0(d_rise), .wd1(d_fall),
        .ra0(fa0), .ra1(fa1), .rd0(pr), .rd1(pf)
    );

    qdr_b4_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .k_timing(k_timing),
        .fetch(fetch), .fetch_first(fetch_first), .pr(pr), .pf(pf),
        .q_rise(q_rise), .q_fall(q_fall), .q_valid(q_valid),
        .q_start(q_start), .echo(echo)
    );
endmodule

// File: rtl/qdr_b4_sram_chk.sv
module qdr_b4_sram_chk
    import qdr_b4_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              k_timing,
    input logic [DATA_W-1:0] q_rise,
    input logic [DATA_W-1:0] q_fall,
    input logic              q_valid,
    input logic              q_start,
    input logic              echo,
    input rd_state_e         rd_state,
    input wr_state_e         wr_state
);
    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_state == RD_B01 |=> rd_state == RD_B23);

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_state == WR_ADDR |=> wr_state == WR_B23);

    // R9
    slot_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_state == WR_ADDR && rd_state != RD_B01) |=> rd_state != RD_B01);

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !q_valid |-> (q_rise == '0 && q_fall == '0 && !q_start));

    // R11
    echo_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> echo != $past(echo));

    // R2
    first_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(q_valid) && k_timing && $past(k_timing))
            |-> (q_start && $past(rd_state) == RD_B01));
endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .k_timing(k_timing),
    .q_rise(q_rise), .q_fall(q_fall), .q_valid(q_valid),
    .q_start(q_start), .echo(echo),
    .rd_state(rd_state), .wr_state(wr_state)
);

// File: tb/qdr_b4_sram_tb.sv
module qdr_b4_sram_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        k_timing = 1'b1;
    logic        rd_n = 1'b1, wr_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [1:0]  be_rise = '0, be_fall = '0;
    logic [15:0] d_rise = '0, d_fall = '0;
    logic [15:0] q_rise, q_fall;
    logic        q_valid, q_start, echo;

    int compared = 0, mismatched = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    qdr_b4_sram u_dut (
        .clk(clk), .rst(rst), .k_timing(k_timing), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .be_rise(be_rise), .be_fall(be_fall),
        .d_rise(d_rise), .d_fall(d_fall), .q_rise(q_rise), .q_fall(q_fall),
        .q_valid(q_valid), .q_start(q_start), .echo(echo)
    );

    // behavioural reference
    logic [15:0] mm [64];
    int          rph = 0, wph = 0;
    logic [5:0]  rb = '0, wb = '0;
    logic        kv = 0, ks = 0, cv = 0, cs = 0, echo_e = 0;
    logic [15:0] kr = '0, kf = '0, cr = '0, cf = '0;

    function automatic logic [5:0] ba(input logic [5:0] a, input int o);
        return {a[5:2], 2'(int'(a[1:0]) + o)};
    endfunction

    task automatic put(input logic [5:0] a, input logic [1:0] be, input logic [15:0] d);
        for (int b = 0; b < 2; b++)
            if (be[b]) mm[a][b*8 +: 8] = d[b*8 +: 8];
    endtask

    always @(posedge clk) begin
        int rn, wn;
        if (rst) begin
            for (int i = 0; i < 64; i++) mm[i] = '0;
            rph = 0; wph = 0; rb = '0; wb = '0; echo_e = 0;
            kv = 0; ks = 0; kr = '0; kf = '0; cv = 0; cs = 0; cr = '0; cf = '0;
        end else begin
            cv = kv; cs = ks; cr = kr; cf = kf;
            kv = 0; ks = 0; kr = '0; kf = '0;
            rn = 0; wn = 0;
            if (rph == 1) begin
                kv = 1; ks = 1; kr = mm[ba(rb, 0)]; kf = mm[ba(rb, 1)]; rn = 2;
            end else if (rph == 2) begin
                kv = 1; kr = mm[ba(rb, 2)]; kf = mm[ba(rb, 3)];
            end
            if (wph == 1) begin
                wb = addr;
                put(ba(wb, 0), be_rise, d_rise); put(ba(wb, 1), be_fall, d_fall); wn = 2;
            end else if (wph == 2) begin
                put(ba(wb, 2), be_rise, d_rise); put(ba(wb, 3), be_fall, d_fall);
            end
            if (!rd_n && rph != 1 && wph != 1) begin rn = 1; rb = addr; end
            if (!wr_n && wph != 1) wn = 1;
            rph = rn; wph = wn;
            echo_e = ~echo_e;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic ev, es;
        logic [15:0] er, ef;
        if (!rst && !done) begin
            ev = k_timing ? kv : cv; es = k_timing ? ks : cs;
            er = k_timing ? kr : cr; ef = k_timing ? kf : cf;
            chk(q_valid == ev, cur_req, "q_valid", 32'(q_valid), 32'(ev));
            chk(q_start == es, cur_req, "q_start", 32'(q_start), 32'(es));
            chk(q_rise == er, cur_req, "q_rise", 32'(q_rise), 32'(er));
            chk(q_fall == ef, cur_req, "q_fall", 32'(q_fall), 32'(ef));
            chk(echo == echo_e, "R11", "echo", 32'(echo), 32'(echo_e));
        end
    end

    task automatic drive(input logic r, input logic w, input logic [5:0] a,
                         input logic [1:0] ber, input logic [1:0] bef,
                         input logic [15:0] dr, input logic [15:0] df);
        @(negedge clk);
        rd_n = r; wr_n = w; addr = a; be_rise = ber; be_fall = bef;
        d_rise = dr; d_fall = df;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1, 1, 6'h3f, 2'b00, 2'b00, 16'h0, 16'h0);
    endtask

    task automatic wburst(input logic [5:0] a, input logic [15:0] seed,
                          input logic [1:0] b0, input logic [1:0] b1);
        drive(1, 0, 6'h00, 2'b00, 2'b00, 16'h0, 16'h0);
        drive(1, 1, a, b0, b1, seed, seed + 16'h0111);
        drive(1, 1, 6'h00, b0, b1, seed + 16'h0222, seed + 16'h0333);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state observed at the ports
        chk(q_valid == 0 && q_start == 0, "R1", "reset flags", {q_valid, q_start}, 0);
        chk(q_rise == 0 && q_fall == 0, "R1", "reset data", {q_rise, q_fall}, 0);
        chk(echo == 0, "R1", "reset echo", 32'(echo), 0);
        rst = 1'b0;
        idle(2);
        cur_req = "R1"; drive(0, 1, 6'd5, 0, 0, 0, 0); idle(4);   // cleared storage
        cur_req = "R6"; wburst(6'd9, 16'hA100, 2'b11, 2'b11); idle(2);
        cur_req = "R3"; drive(0, 1, 6'd9, 0, 0, 0, 0); idle(4);   // wraps 9,10,11,8
        cur_req = "R2"; wburst(6'd20, 16'h5000, 2'b11, 2'b11);
        drive(0, 1, 6'd20, 0, 0, 0, 0); idle(4);
        cur_req = "R8"; wburst(6'd20, 16'hC3C3, 2'b01, 2'b10);
        drive(0, 1, 6'd21, 0, 0, 0, 0); idle(4);
        cur_req = "R4"; drive(0, 1, 6'd8, 0, 0, 0, 0);
        drive(0, 1, 6'd20, 0, 0, 0, 0);                           // ignored
        drive(0, 1, 6'd23, 0, 0, 0, 0); idle(1);
        cur_req = "R5"; idle(4);
        cur_req = "R7"; drive(1, 0, 0, 0, 0, 0, 0);
        drive(1, 0, 6'd32, 2'b11, 2'b11, 16'h7001, 16'h7002);     // second request ignored
        drive(1, 1, 6'd40, 2'b11, 2'b11, 16'h7003, 16'h7004);
        idle(2); drive(0, 1, 6'd32, 0, 0, 0, 0); idle(2);
        drive(0, 1, 6'd40, 0, 0, 0, 0); idle(4);
        cur_req = "R9"; drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 1, 6'd44, 2'b11, 2'b11, 16'h9001, 16'h9002);     // read on write address edge
        drive(1, 1, 0, 2'b11, 2'b11, 16'h9003, 16'h9004); idle(4);
        cur_req = "R10"; drive(0, 0, 6'd9, 0, 0, 0, 0);
        drive(1, 1, 6'd9, 2'b11, 2'b11, 16'hBEEF, 16'hCAFE);
        drive(1, 1, 0, 2'b11, 2'b11, 16'hF00D, 16'hD00D); idle(2);
        drive(0, 1, 6'd9, 0, 0, 0, 0); idle(4);
        cur_req = "R12"; k_timing = 1'b0; idle(2);
        drive(0, 1, 6'd44, 0, 0, 0, 0); drive(1, 1, 0, 0, 0, 0, 0);
        drive(0, 1, 6'd9, 0, 0, 0, 0); idle(6);
        k_timing = 1'b1; idle(2);
        cur_req = "R10";
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 499) k_timing = ~k_timing;
            drive(logic'($urandom_range(0, 2) != 0), logic'($urandom_range(0, 2) != 0),
                  6'($urandom), 2'($urandom), 2'($urandom), 16'($urandom), 16'($urandom));
        end
        idle(6);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++; mismatched++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule